// File: doc/BRIEF.md
# Configuration Cache Controller

This controller sits in front of the loader of a reconfigurable array. It keeps a small set of whole array configurations that were recently swapped out of the array, so that a frequently reused configuration can be brought back without going to memory. Each stored configuration is a fixed number of wide words, and each entry is tagged by the configuration's start address.

A load request carries a configuration start address and is accepted only while the array reports itself idle and no earlier load is in progress. On a hit, the stored words are replayed to the array, one per cycle, with no memory traffic. On a miss, the controller issues one burst read to memory. It forwards each returned word to the array in the cycle it arrives and writes it into a victim entry. When the last word arrives, that entry is installed. The victim is an empty entry if one exists, otherwise the least recently used one. A flush input drops every stored configuration at once.

Top module: `cfg_cache_ctrl`

## Requirements
- R1: After reset `busy`, `cfg_valid`, `mem_req_valid`, `hit_pulse` and `miss_pulse` are low, `req_ready` is high while `coproc_idle` is high, and the cache is empty, so the first request of any address misses.
- R2: `req_ready` is high only while no load is in progress, `coproc_idle` is high and `flush` is low. A request presented at any other time is not accepted, and `busy` stays low if the block was idle.
- R3: On a hit (five words per configuration by default), `cfg_valid` is high for exactly 5 consecutive cycles, starting the cycle after acceptance. Word i of the stored configuration appears on `cfg_data` in the i-th of those cycles, and `cfg_last` is high only in the 5th. No memory request is made, and `busy` is low in the cycle after the last word.
- R4: On a miss, `mem_req_valid` rises the cycle after acceptance, with `mem_req_addr` equal to the request address, and both hold steady until `mem_req_ready` is seen. Each later cycle with `mem_rsp_valid` high drives `cfg_valid` high with `cfg_data` equal to `mem_rsp_data` in that same cycle. `cfg_last` is high on the 5th word, and `cfg_valid` is low in cycles without a response word.
- R5: A miss that completes without a flush installs the configuration. A later request for the same address hits and replays the same words that memory returned.
- R6: `hit_pulse` or `miss_pulse` (never both) is high for exactly the one cycle after a request is accepted, according to the lookup result.
- R7: A miss fills the lowest-numbered empty entry if one exists, otherwise the least recently used entry. Both a hit and a completed fill make the entry the most recently used.
- R8: `flush` clears every stored configuration in one cycle. If `flush` is high at any point between the acceptance of a miss and its last response word (inclusive), that fill does not become valid. The fill still delivers all its words to the array.
- R9: `busy` is high from the cycle after acceptance until the load's last word has been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coproc_idle | input | 1 | Array is idle; loads may be accepted |
| flush | input | 1 | Drop all stored configurations |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Load request accepted this cycle if valid |
| req_addr | input | ADDR_W | Configuration start address |
| busy | output | 1 | A load is in progress |
| hit_pulse | output | 1 | Last accepted request hit |
| miss_pulse | output | 1 | Last accepted request missed |
| cfg_valid | output | 1 | Configuration word to the array is valid |
| cfg_data | output | WORD_W | Configuration word to the array |
| cfg_last | output | 1 | Final word of the configuration |
| mem_req_valid | output | 1 | Burst read request to memory |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Burst read start address |
| mem_rsp_valid | input | 1 | Memory returns a word |
| mem_rsp_data | input | WORD_W | Returned configuration word |

## Verification
Two events can land in the same cycle: a flush, and the final response word of a miss that would install an entry. The bench raises `flush` together with a chosen response word, either the last word or an earlier one. It then requests the same address again and expects a miss, and it also checks that every word of the cancelled fill still reached the array. A second overlap, a request arriving during a replay or together with a flush, is provoked by holding `req_valid` high in those cycles and judged by `req_ready` staying low and the lookup pulses staying silent. All hit/miss outcomes are compared against a bench model of tags, valid bits and recency ages.

// File: rtl/cfgc_pkg.sv
// Shared types for the configuration cache controller.
package cfgc_pkg;
    // Sequencer states: waiting, replaying a hit, requesting memory, receiving a fill.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REPLAY = 2'd1,
        ST_FETCH  = 2'd2,
        ST_FILL   = 2'd3
    } cc_state_e;
endpackage

// File: rtl/cfgc_tag_store.sv
// Tag and valid storage with a fully associative lookup.
// Assumes at most one valid entry carries a given tag (the controller installs
// only after a miss). Flush has priority over a same-cycle install.
module cfgc_tag_store #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   look_tag,
    output logic               look_hit,
    output logic [IDX_W-1:0]   look_idx,
    input  logic               inst_en,
    input  logic [IDX_W-1:0]   inst_idx,
    input  logic [TAG_W-1:0]   inst_tag,
    input  logic               flush,
    output logic [ENTRIES-1:0] valid_o
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    // Valid bits: cleared by reset or flush, set by an install.
    always_ff @(posedge clk) begin
        if (!rst_n)       valid_q <= '0;
        else if (flush)   valid_q <= '0;
        else if (inst_en) valid_q[inst_idx] <= 1'b1;
    end

    // Tag registers: written on install only.
    always_ff @(posedge clk) begin
        if (inst_en) tag_q[inst_idx] <= inst_tag;
    end

    // Per-entry compare against the looked-up address.
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = valid_q[g] && (tag_q[g] == look_tag);
        end
    endgenerate

    // Encode the matching entry into an index.
    always_comb begin
        look_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) look_idx = IDX_W'(i);
    end

    assign look_hit = |match;
    assign valid_o  = valid_q;

    // R8: a flush leaves no entry valid in the following cycle.
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
    // R5: an address never matches two entries.
    a_r5_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/cfgc_lru.sv
// Least-recently-used tracking with one age per entry (0 = newest).
// Ages always form a permutation of 0..ENTRIES-1. The victim is the lowest
// empty entry, otherwise the entry of the highest age.
module cfgc_lru #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_en,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_i,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] age_q [ENTRIES];
    logic             found;
    logic [IDX_W-1:0] chk_idx;
    logic             chk_vld;

    // Age update: touched entry becomes newest, younger ones grow one older.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n)
                age_q[i] <= IDX_W'(i);
            else if (touch_en) begin
                if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    // Victim choice: lowest empty entry first, then the oldest entry.
    always_comb begin
        victim_idx = '0;
        found      = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_i[i] && !found) begin
                victim_idx = IDX_W'(i);
                found      = 1'b1;
            end
        end
        if (!found)
            for (int i = 0; i < ENTRIES; i++)
                if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
    end

    // Checker state: remembers the last touched entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_vld <= 1'b0;
            chk_idx <= '0;
        end else begin
            chk_vld <= touch_en;
            chk_idx <= touch_idx;
        end
    end

    // R7: the entry touched last cycle is now the newest.
    a_r7_touch_newest: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |-> (age_q[chk_idx] == '0));
endmodule

// File: rtl/cfgc_data_store.sv
// Configuration word storage: ENTRIES configurations of WORDS words each.
// One write port and one combinational read port. Contents are not reset;
// the tag store decides what is meaningful.
module cfgc_data_store #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 5,
    parameter int WORD_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int CNT_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_entry,
    input  logic [CNT_W-1:0]  wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_entry,
    input  logic [CNT_W-1:0]  rd_word,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [ENTRIES][WORDS];

    // Store one arriving fill word.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_entry][wr_word] <= wr_data;
    end

    assign rd_data = mem_q[rd_entry][rd_word];
endmodule

// File: rtl/cfg_cache_ctrl.sv
// Configuration cache controller top.
// Accepts a load while the array is idle, replays a stored configuration on a
// hit, or fetches it with one burst read on a miss while installing it into
// the victim entry. Memory must return exactly WORDS words per accepted request.
module cfg_cache_ctrl
    import cfgc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 5,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coproc_idle,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              hit_pulse,
    output logic              miss_pulse,
    output logic              cfg_valid,
    output logic [WORD_W-1:0] cfg_data,
    output logic              cfg_last,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int CNT_W = $clog2(WORDS);
    localparam logic [CNT_W-1:0] LAST_W = CNT_W'(WORDS - 1);

    cc_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [IDX_W-1:0]   idx_q;
    logic               kill_q;

    logic               accept, look_hit, fill_beat, fill_last, replay_last;
    logic               touch_en, inst_en;
    logic [IDX_W-1:0]   look_idx, victim_idx, touch_idx;
    logic [ENTRIES-1:0] valid_vec;
    logic [WORD_W-1:0]  rd_data;

    assign req_ready   = (state_q == ST_IDLE) && coproc_idle && !flush;
    assign accept      = req_valid && req_ready;
    assign fill_beat   = (state_q == ST_FILL) && mem_rsp_valid;
    assign fill_last   = fill_beat && (cnt_q == LAST_W);
    assign replay_last = (state_q == ST_REPLAY) && (cnt_q == LAST_W);
    assign touch_en    = (accept && look_hit) || fill_last;
    assign touch_idx   = accept ? look_idx : idx_q;
    assign inst_en     = fill_last && !flush && !kill_q;

    cfgc_tag_store #(.ENTRIES(ENTRIES), .TAG_W(ADDR_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .look_tag(req_addr), .look_hit(look_hit), .look_idx(look_idx),
        .inst_en(inst_en), .inst_idx(idx_q), .inst_tag(addr_q),
        .flush(flush), .valid_o(valid_vec)
    );

    cfgc_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_idx(touch_idx),
        .valid_i(valid_vec), .victim_idx(victim_idx)
    );

    cfgc_data_store #(.ENTRIES(ENTRIES), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
        .clk(clk),
        .wr_en(fill_beat), .wr_entry(idx_q), .wr_word(cnt_q), .wr_data(mem_rsp_data),
        .rd_entry(idx_q), .rd_word(cnt_q), .rd_data(rd_data)
    );

    // Sequencer: lookup on accept, then replay or fetch-and-fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    addr_q  <= req_addr;
                    cnt_q   <= '0;
                    idx_q   <= look_hit ? look_idx : victim_idx;
                    state_q <= look_hit ? ST_REPLAY : ST_FETCH;
                end
                ST_REPLAY: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (replay_last) state_q <= ST_IDLE;
                end
                ST_FETCH: if (mem_req_ready) state_q <= ST_FILL;
                ST_FILL: if (fill_beat) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (fill_last) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Cancel flag: a flush during a fetch keeps that fill from being installed.
    always_ff @(posedge clk) begin
        if (!rst_n || accept)                                  kill_q <= 1'b0;
        else if (flush && (state_q == ST_FETCH || state_q == ST_FILL)) kill_q <= 1'b1;
    end

    // Lookup result pulses, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_pulse  <= 1'b0;
            miss_pulse <= 1'b0;
        end else begin
            hit_pulse  <= accept && look_hit;
            miss_pulse <= accept && !look_hit;
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign cfg_valid     = (state_q == ST_REPLAY) || fill_beat;
    assign cfg_data      = (state_q == ST_REPLAY) ? rd_data : mem_rsp_data;
    assign cfg_last      = replay_last || fill_last;
    assign mem_req_valid = (state_q == ST_FETCH);
    assign mem_req_addr  = addr_q;

    // R2: no request is taken while a load is in progress.
    a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);
    // R9: an accepted request makes the block busy next cycle.
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R3: a hit starts delivering words the next cycle.
    a_r3_replay_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && look_hit) |=> (cfg_valid && !mem_req_valid));
    // R3: the final replayed word ends the load.
    a_r3_replay_ends: assert property (@(posedge clk) disable iff (!rst_n)
        replay_last |=> !busy);
    // R4: the memory request is held with a stable address until taken.
    a_r4_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R6: at most one lookup pulse.
    a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_pulse, miss_pulse}));
endmodule

// File: tb/test_cfg_cache_ctrl.sv
// Bench for cfg_cache_ctrl: directed corners plus seeded random loads,
// checked against a model of tags, valid bits and recency ages.
module test_cfg_cache_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coproc_idle = 1'b1, flush = 1'b0, req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        req_ready, busy, hit_pulse, miss_pulse, cfg_valid, cfg_last;
    logic        mem_req_valid;
    logic [31:0] cfg_data, mem_req_addr;

    int checks = 0, failures = 0;
    bit finished = 0;

    bit          mv [4];
    logic [31:0] mt [4];
    int          mage [4];

    always #10 clk = ~clk;

    cfg_cache_ctrl i_cfg_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .coproc_idle(coproc_idle), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .busy(busy), .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
        .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_last(cfg_last),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] a, input int i);
        return (a * 32'h9E37_79B1) ^ (32'h0101_0101 * (i + 1)) ^ 32'(i);
    endfunction

    function automatic int m_lookup(input logic [31:0] a);
        for (int k = 0; k < 4; k++) if (mv[k] && mt[k] == a) return k;
        return -1;
    endfunction

    function automatic int m_victim();
        for (int k = 0; k < 4; k++) if (!mv[k]) return k;
        for (int k = 0; k < 4; k++) if (mage[k] == 3) return k;
        return 0;
    endfunction

    task automatic m_touch(input int e);
        int old = mage[e];
        for (int k = 0; k < 4; k++) if (mage[k] < old) mage[k]++;
        mage[e] = 0;
    endtask

    task automatic m_flush();
        for (int k = 0; k < 4; k++) mv[k] = 0;
    endtask

    // One load; flush_beat >= 0 raises flush with that response word.
    task automatic do_load(input logic [31:0] a, input int flush_beat);
        int e = m_lookup(a);
        int v;
        @(negedge clk);
        req_valid = 1; req_addr = a;
        #1 chk("R2", "ready when idle", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk("R9", "busy after accept", 32'(busy), 1);
        chk("R6", "hit pulse", 32'(hit_pulse), 32'(e >= 0));
        chk("R6", "miss pulse", 32'(miss_pulse), 32'(e < 0));
        if (e >= 0) begin
            m_touch(e);
            for (int i = 0; i < 5; i++) begin
                chk("R3", "replay valid", 32'(cfg_valid), 1);
                chk("R3", "replay data", cfg_data, word_of(a, i));
                chk("R3", "replay last", 32'(cfg_last), 32'(i == 4));
                chk("R3", "no mem req on hit", 32'(mem_req_valid), 0);
                if (i == 2) begin
                    req_valid = 1; req_addr = a + 32'h40;
                    #1 chk("R2", "ready low while busy", 32'(req_ready), 0);
                end
                @(negedge clk);
                req_valid = 0;
                #1;
            end
            chk("R3", "idle after 5 words", 32'(busy), 0);
            chk("R3", "valid ends", 32'(cfg_valid), 0);
            chk("R2", "no pulse from held request", 32'(hit_pulse | miss_pulse), 0);
        end else begin
            v = m_victim();
            chk("R4", "mem req raised", 32'(mem_req_valid), 1);
            chk("R4", "mem req addr", mem_req_addr, a);
            chk("R4", "no word before fill", 32'(cfg_valid), 0);
            repeat ($urandom_range(0, 3)) begin
                @(negedge clk);
                #1;
                chk("R4", "mem req held", 32'(mem_req_valid), 1);
                chk("R4", "mem addr held", mem_req_addr, a);
            end
            mem_req_ready = 1;
            for (int i = 0; i < 5; i++) begin
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    mem_req_ready = 0; mem_rsp_valid = 0; flush = 0;
                    #1 chk("R4", "no word in gap", 32'(cfg_valid), 0);
                end
                @(negedge clk);
                mem_req_ready = 0; mem_rsp_valid = 1; mem_rsp_data = word_of(a, i);
                flush = (i == flush_beat);
                if (flush) m_flush();
                #1;
                chk("R4", "fill valid", 32'(cfg_valid), 1);
                chk("R4", "fill data", cfg_data, word_of(a, i));
                chk("R4", "fill last", 32'(cfg_last), 32'(i == 4));
            end
            @(negedge clk);
            mem_rsp_valid = 0; flush = 0;
            #1;
            chk("R9", "idle after fill", 32'(busy), 0);
            chk("R4", "valid ends after fill", 32'(cfg_valid), 0);
            m_touch(v);
            if (flush_beat < 0) begin
                mv[v] = 1; mt[v] = a;
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1; req_valid = 1; req_addr = 32'h1000;
        #1 chk("R2", "ready low during flush", 32'(req_ready), 0);
        m_flush();
        @(negedge clk);
        flush = 0; req_valid = 0;
        #1 chk("R2", "flush cycle request ignored", 32'(busy), 0);
    endtask

    initial begin
        process::self().srandom(32'd20240611);
        for (int k = 0; k < 4; k++) begin mv[k] = 0; mt[k] = '0; mage[k] = k; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "busy after reset", 32'(busy), 0);
        chk("R1", "ready after reset", 32'(req_ready), 1);
        chk("R1", "cfg_valid after reset", 32'(cfg_valid), 0);
        chk("R1", "mem req after reset", 32'(mem_req_valid), 0);
        chk("R1", "pulses after reset", 32'(hit_pulse | miss_pulse), 0);

        // R2: array active, request is not taken.
        @(negedge clk);
        coproc_idle = 0; req_valid = 1; req_addr = 32'h1000;
        #1 chk("R2", "ready low when array active", 32'(req_ready), 0);
        @(negedge clk);
        #1 chk("R2", "not busy when array active", 32'(busy), 0);
        coproc_idle = 1; req_valid = 0;

        // R1/R5/R7: fill four entries, then hit, then evict the oldest.
        do_load(32'h1000, -1);
        do_load(32'h2000, -1);
        do_load(32'h3000, -1);
        do_load(32'h4000, -1);
        do_load(32'h1000, -1);
        do_load(32'h5000, -1);
        do_load(32'h1000, -1);
        do_load(32'h2000, -1);
        do_load(32'h3000, -1);

        // R8: flush on the last fill word and mid-fill cancel the install.
        do_load(32'h6000, 4);
        do_load(32'h6000, -1);
        do_load(32'h6000, -1);
        do_load(32'h7000, 1);
        do_load(32'h7000, -1);
        do_flush();
        do_load(32'h6000, -1);

        // Random mix.
        for (int n = 0; n < 80; n++) begin
            logic [31:0] a = 32'h1000 * $urandom_range(1, 6);
            int fb = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 4)) : -1;
            if ($urandom_range(0, 19) == 0) do_flush();
            do_load(a, fb);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule